// File: doc/BRIEF.md
# Circuit Reservation Handshake Controller

This controller sits in each node of a mesh and handles the handshake that must finish before any bulk payload goes onto a link with no buffering. In the source role it accepts one transfer request, which gives a destination coordinate and a payload length. It then sends a configure flit on the electrical control link. While that flit travels, it claims the switches along its route. The controller waits for a short acknowledge pulse that returns over the reserved data path. After the pulse it raises a stream enable for exactly the requested number of cycles. It then sends a release flit that frees the route. If no acknowledge arrives within a set window, it releases the route anyway and flags the failed attempt.

In the destination role the same controller watches its incoming control flits. When a configure flit names this node, it answers with a one-cycle acknowledge pulse. Payload is never stored or reordered inside the block, so the stream enable is the only gate on data movement. Routing of control flits and the electrical/optical conversion are left to neighbouring blocks.

Top module: `path_setup_ctl`

## Requirements
- R1: Every control flit is FLIT_W (32) bits wide. Bits [31:30] hold the kind: 00 means configure, 01 means release, and 10 is reserved. Bits [29:18] hold the destination x,y,z with CRD_W=4 bits each, x highest. Bits [17:6] hold the sending node's own x,y,z in the same order. Bits [5:0] are zero.
- R2: After reset the block is idle. req_ready is 1, and tx_flit_valid, stream_en, stream_done, timeout_err and ack_out are all 0.
- R3: req_ready is high only while idle. A request taken with req_valid && req_ready makes tx_flit_valid rise on the next cycle, carrying a configure flit to the requested destination. req_valid has no effect while the block is busy.
- R4: A flit offered on tx_flit stays valid and unchanged until the cycle in which tx_flit_ready is high.
- R5: Once the configure flit is taken, an ack_in pulse in any of the next ACK_WAIT cycles is accepted. An ack_in at any other time has no effect.
- R6: For a length L ≥ 1, stream_en is high for exactly L consecutive cycles, starting the cycle after the acknowledge. stream_done is high only in the last of those cycles.
- R7: For a length of 0, the acknowledge is followed directly by the release flit, and stream_en never rises.
- R8: After streaming, the block offers a release flit to the same destination. When that flit is taken, the block returns to idle.
- R9: If ACK_WAIT cycles pass in the wait state with no ack_in, the block offers a release flit. When that flit is taken, timeout_err is high for exactly one cycle, which is the first idle cycle.
- R10: rx_flit_ready is always 1. A received configure flit whose destination equals (my_x,my_y,my_z) produces ack_out high for one cycle, in the cycle after it is received.
- R11: A received release flit, a configure flit for another node, or rx_flit data without rx_flit_valid produces no ack_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_x | input | CRD_W | This node's x coordinate |
| my_y | input | CRD_W | This node's y coordinate |
| my_z | input | CRD_W | This node's z coordinate |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_dx | input | CRD_W | Requested destination x |
| req_dy | input | CRD_W | Requested destination y |
| req_dz | input | CRD_W | Requested destination z |
| req_len | input | LEN_W | Payload length in cycles |
| tx_flit_valid | output | 1 | Outgoing control flit present |
| tx_flit_ready | input | 1 | Control link takes the flit |
| tx_flit | output | FLIT_W | Outgoing control flit |
| ack_in | input | 1 | Acknowledge pulse returned over the data path |
| stream_en | output | 1 | Payload may move this cycle |
| stream_done | output | 1 | Last payload cycle |
| timeout_err | output | 1 | One-cycle flag after an unacknowledged attempt |
| rx_flit_valid | input | 1 | Incoming control flit present |
| rx_flit_ready | output | 1 | Incoming flit taken (always 1) |
| rx_flit | input | FLIT_W | Incoming control flit |
| ack_out | output | 1 | Acknowledge pulse toward the sender |

## Verification
The assertions check, on every cycle, the local rules of the handshake. A held flit stays stable under backpressure. stream_done falls inside stream_en, and stream_en ends right after it. A taken request leads to a configure flit. The first stream cycle follows an ack_in. Every ack_out is preceded by a matching configure flit, and every error flag by a taken release flit. What only the bench scenarios can show is the counting: the exact stream length, acceptance of an acknowledge in the last cycle of the window, the moment of a timeout, and the handling of zero length. The bench shows these by comparing every output with a behavioural model across normal, backpressured, timed-out and destination-side traffic.

// File: rtl/path_setup_ctl.sv
module path_setup_ctl #(
  parameter int CRD_W    = 4,
  parameter int LEN_W    = 16,
  parameter int ACK_WAIT = 256,
  parameter int FLIT_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CRD_W-1:0]  my_x,
  input  logic [CRD_W-1:0]  my_y,
  input  logic [CRD_W-1:0]  my_z,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CRD_W-1:0]  req_dx,
  input  logic [CRD_W-1:0]  req_dy,
  input  logic [CRD_W-1:0]  req_dz,
  input  logic [LEN_W-1:0]  req_len,
  output logic              tx_flit_valid,
  input  logic              tx_flit_ready,
  output logic [FLIT_W-1:0] tx_flit,
  input  logic              ack_in,
  output logic              stream_en,
  output logic              stream_done,
  output logic              timeout_err,
  input  logic              rx_flit_valid,
  output logic              rx_flit_ready,
  input  logic [FLIT_W-1:0] rx_flit,
  output logic              ack_out
);
  localparam int ADDR_W = 3 * CRD_W;
  localparam int DST_LO = FLIT_W - 2 - ADDR_W;
  localparam int SRC_LO = DST_LO - ADDR_W;
  localparam int WT_W   = $clog2(ACK_WAIT + 1);
  localparam logic [1:0] K_CFG = 2'b00;
  localparam logic [1:0] K_REL = 2'b01;

  typedef enum logic [2:0] {S_IDLE, S_CFG, S_WAIT, S_STRM, S_REL} st_t;

  st_t               st;
  logic [ADDR_W-1:0] dst;
  logic [LEN_W-1:0]  left;
  logic [WT_W-1:0]   wcnt;
  logic              aborted;
  logic              err_q;
  logic              ack_q;

  wire               tx_take  = tx_flit_valid && tx_flit_ready;
  wire [ADDR_W-1:0]  self_adr = {my_x, my_y, my_z};
  wire               rx_hit   = rx_flit_valid && rx_flit[FLIT_W-1 -: 2] == K_CFG
                                && rx_flit[DST_LO +: ADDR_W] == self_adr;

  assign req_ready     = st == S_IDLE;
  assign tx_flit_valid = st == S_CFG || st == S_REL;
  assign tx_flit       = {(st == S_REL) ? K_REL : K_CFG, dst, self_adr, {SRC_LO{1'b0}}};
  assign stream_en     = st == S_STRM;
  assign stream_done   = stream_en && left == LEN_W'(1);
  assign timeout_err   = err_q;
  assign rx_flit_ready = 1'b1;
  assign ack_out       = ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      dst     <= '0;
      left    <= '0;
      wcnt    <= '0;
      aborted <= 1'b0;
      err_q   <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      ack_q <= rx_hit;
      unique case (st)
        S_IDLE: if (req_valid) begin
          dst  <= {req_dx, req_dy, req_dz};
          left <= req_len;
          st   <= S_CFG;
        end
        S_CFG: if (tx_take) begin
          wcnt <= '0;
          st   <= S_WAIT;
        end
        S_WAIT: begin
          if (ack_in) begin
            aborted <= 1'b0;
            st      <= (left == '0) ? S_REL : S_STRM;
          end else if (wcnt == WT_W'(ACK_WAIT - 1)) begin
            aborted <= 1'b1;
            st      <= S_REL;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        S_STRM: begin
          if (left == LEN_W'(1)) st <= S_REL;
          left <= left - 1'b1;
        end
        S_REL: if (tx_take) begin
          err_q <= aborted;
          st    <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/path_setup_ctl_chk.sv
module path_setup_ctl_chk #(
  parameter int CRD_W    = 4,
  parameter int LEN_W    = 16,
  parameter int ACK_WAIT = 256,
  parameter int FLIT_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CRD_W-1:0]  my_x,
  input logic [CRD_W-1:0]  my_y,
  input logic [CRD_W-1:0]  my_z,
  input logic              req_valid,
  input logic              req_ready,
  input logic              tx_flit_valid,
  input logic              tx_flit_ready,
  input logic [FLIT_W-1:0] tx_flit,
  input logic              ack_in,
  input logic              stream_en,
  input logic              stream_done,
  input logic              timeout_err,
  input logic              rx_flit_valid,
  input logic [FLIT_W-1:0] rx_flit,
  input logic              ack_out
);
  localparam int DST_LO = FLIT_W - 2 - 3 * CRD_W;

  p_req_to_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> tx_flit_valid && tx_flit[FLIT_W-1 -: 2] == 2'b00);

  p_hold_flit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flit_valid && !tx_flit_ready |=> tx_flit_valid && $stable(tx_flit));

  p_stream_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stream_en) |-> $past(ack_in));

  p_done_inside_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stream_done |-> stream_en && !tx_flit_valid && !req_ready);

  p_done_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stream_done |=> !stream_en && tx_flit_valid);

  p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> !timeout_err);

  p_err_after_rel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> req_ready && $past(tx_flit_valid && tx_flit_ready
                                      && tx_flit[FLIT_W-1 -: 2] == 2'b01));

  p_ack_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out |-> $past(rx_flit_valid && rx_flit[FLIT_W-1 -: 2] == 2'b00
                      && rx_flit[DST_LO +: 3*CRD_W] == {my_x, my_y, my_z}));
endmodule

bind path_setup_ctl path_setup_ctl_chk #(
  .CRD_W(CRD_W), .LEN_W(LEN_W), .ACK_WAIT(ACK_WAIT), .FLIT_W(FLIT_W)
) u_chk (.*);

// File: tb/sim_path_setup_ctl.sv
`timescale 1ns/1ps
module sim_path_setup_ctl;
  localparam int CW = 4, LW = 8, AW = 8, FW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] my_x = 4'd2, my_y = 4'd1, my_z = 4'd1;
  logic req_valid = 0, tx_flit_ready = 0, ack_in = 0, rx_flit_valid = 0;
  logic [CW-1:0] req_dx = 0, req_dy = 0, req_dz = 0;
  logic [LW-1:0] req_len = 0;
  logic [FW-1:0] rx_flit = 0;
  logic req_ready, tx_flit_valid, stream_en, stream_done, timeout_err, rx_flit_ready, ack_out;
  logic [FW-1:0] tx_flit;

  path_setup_ctl #(.CRD_W(CW), .LEN_W(LW), .ACK_WAIT(AW), .FLIT_W(FW)) u0 (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int m_st = 0, m_wait = 0, m_left = 0, m_len = 0;
  bit m_abort = 0, m_err = 0, m_ack = 0, m_rstseen = 0;
  logic [CW-1:0] m_dx = 0, m_dy = 0, m_dz = 0;

  function automatic logic [FW-1:0] mk(input logic [1:0] k, input logic [CW-1:0] a, b, c,
                                       input logic [CW-1:0] d, e, f);
    return {k, a, b, c, d, e, f, 6'b0};
  endfunction

  always @(posedge clk) begin
    bit e;
    if (!rst_n) begin
      m_st = 0; m_wait = 0; m_left = 0; m_abort = 0; m_err = 0; m_ack = 0; m_rstseen = 1;
    end else begin
      e = 0;
      case (m_st)
        0: if (req_valid) begin
             m_dx = req_dx; m_dy = req_dy; m_dz = req_dz; m_len = int'(req_len); m_st = 1;
           end
        1: if (tx_flit_ready) begin m_st = 2; m_wait = 0; end
        2: if (ack_in) begin
             m_abort = 0;
             if (m_len == 0) m_st = 4; else begin m_st = 3; m_left = m_len; end
           end else if (m_wait == AW - 1) begin m_st = 4; m_abort = 1; end
           else m_wait++;
        3: if (m_left == 1) m_st = 4; else m_left--;
        4: if (tx_flit_ready) begin m_st = 0; e = m_abort; end
        default: m_st = 0;
      endcase
      m_err = e;
      m_ack = rx_flit_valid && rx_flit[31:30] == 2'b00 && rx_flit[29:18] == {my_x, my_y, my_z};
    end
  end

  task automatic chk(input string tag, input logic [FW-1:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (m_rstseen) begin
    chk("R2/R3 req_ready", FW'(req_ready), FW'(m_st == 0));
    chk("R3/R8 tx_flit_valid", FW'(tx_flit_valid), FW'(m_st == 1 || m_st == 4));
    if (m_st == 1 || m_st == 4)
      chk("R1/R4 tx_flit", tx_flit, mk((m_st == 4) ? 2'b01 : 2'b00, m_dx, m_dy, m_dz, my_x, my_y, my_z));
    chk("R5/R6/R7 stream_en", FW'(stream_en), FW'(m_st == 3));
    chk("R6 stream_done", FW'(stream_done), FW'(m_st == 3 && m_left == 1));
    chk("R9 timeout_err", FW'(timeout_err), FW'(m_err));
    chk("R10/R11 ack_out", FW'(ack_out), FW'(m_ack));
    chk("R10 rx_flit_ready", FW'(rx_flit_ready), 1);
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic request(input int x, y, z, len);
    req_dx = CW'(x); req_dy = CW'(y); req_dz = CW'(z); req_len = LW'(len);
    req_valid = 1; cyc(1); req_valid = 0;
  endtask

  task automatic transfer(input int len, input int ack_delay, input int cfg_stall);
    request(3, 0, 1, len);
    tx_flit_ready = 0; cyc(cfg_stall);
    tx_flit_ready = 1; cyc(1); tx_flit_ready = 0;
    cyc(ack_delay);
    ack_in = 1; cyc(1); ack_in = 0;
    cyc(len + 2);
    tx_flit_ready = 1; cyc(1); tx_flit_ready = 0;
    cyc(2);
  endtask

  initial begin
    cyc(3);
    rst_n = 1; cyc(2);
    transfer(5, 2, 0);            // R6 R8 normal
    transfer(3, 1, 3);            // R4 backpressure on configure
    transfer(1, 0, 0);            // R6 length one
    transfer(0, 1, 1);            // R7 length zero
    transfer(4, AW - 1, 0);       // R5 last cycle of window
    // R9 timeout
    request(1, 2, 3, 4);
    tx_flit_ready = 1; cyc(1); tx_flit_ready = 0;
    cyc(AW + 3);
    tx_flit_ready = 1; cyc(1); tx_flit_ready = 0;
    cyc(3);
    // R5 ack while idle ignored; R3 req while busy ignored
    ack_in = 1; cyc(2); ack_in = 0;
    request(5, 5, 5, 6);
    req_dx = 4'd9; req_valid = 1; tx_flit_ready = 0; cyc(2);
    tx_flit_ready = 1; cyc(1); tx_flit_ready = 0; req_valid = 0;
    cyc(1); ack_in = 1; cyc(1);
    cyc(2); ack_in = 1; cyc(1); ack_in = 0;   // ack during stream ignored
    cyc(5);
    tx_flit_ready = 1; cyc(1); tx_flit_ready = 0; cyc(2);
    // R10 R11 destination role
    rx_flit = mk(2'b00, my_x, my_y, my_z, 4'd7, 4'd7, 4'd0); rx_flit_valid = 1; cyc(1);
    rx_flit_valid = 0; cyc(2);
    rx_flit_valid = 1; cyc(2); rx_flit_valid = 0; cyc(1);
    rx_flit = mk(2'b01, my_x, my_y, my_z, 4'd7, 4'd7, 4'd0); rx_flit_valid = 1; cyc(1);
    rx_flit = mk(2'b00, my_x, my_y, 4'd0, 4'd7, 4'd7, 4'd0); cyc(1);
    rx_flit = mk(2'b10, my_x, my_y, my_z, 4'd7, 4'd7, 4'd0); cyc(1);
    rx_flit_valid = 0; rx_flit = mk(2'b00, my_x, my_y, my_z, 4'd0, 4'd0, 4'd0); cyc(2);
    // both roles at once
    fork
      transfer(3, 2, 1);
      begin rx_flit_valid = 1; cyc(4); rx_flit_valid = 0; end
    join
    cyc(3);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired, actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule